// File: doc/BRIEF.md
# Multi-Channel Digital Input Filter

This block conditions the four digital input lines of a field-bus slave before their values go into the slave's response. Each line can be inverted, and each can be passed through a debounce filter. All filtered lines share one 3-bit time-constant code. Seven of the eight codes give a timed filter: a filtered line takes a new level only after its conditioned input has held that level for the selected time.

The eighth code swaps the timer for qualification by bus data-exchange events. The line is sampled on each exchange strobe, and a value is accepted only when two consecutive samples agree. After each sample, further sampling is locked out for a short window. Because of this, a master that repeats a request at once cannot validate data with two strobes in quick succession.

A pin-gating flag and a parameter pin together choose, at run time, whether the response uses the filtered or the conditioned raw values. The filters keep running whichever values are selected. Timing comes from a sub-tick pulse (`tick_i`, nominally one per 8 µs, which is 1/16 of the 128 µs base). Because of this pulse, a realised filter time may be up to one sub-tick short of nominal but is never longer. While `init_done_i` is low, all filter state is cleared.

Top module: `flt_input_cond`

## Requirements
- R1: For codes 0 to 6, the filter time is 16<<code sub-ticks (128<<code µs). A filtered channel whose conditioned input differs from its filtered value takes that input at the clock edge where the 16<<code-th `tick_i` pulse since the difference began is consumed. Its filtered value never changes at an edge without a tick.
- R2: In timed modes, if the conditioned input returns to the filtered level before the time expires, the count restarts from zero.
- R3: The conditioned input of channel n is `raw_i[n] XOR inv_cfg_i[n]`, and inversion is applied before filtering.
- R4: A channel whose bit n of `flt_en_i` is 0 drives `data_o[n]` with its conditioned input in the same cycle.
- R5: While `init_done_i` is low, all filtered values, counters, sample history and lockout are cleared at each clock edge, so enabled channels read 0 until filtering produces a new value.
- R6: With code 7, a sample is taken at each accepted `dx_strobe_i` cycle. The filtered value takes the sampled level only when it equals the previous sample, and the sample history starts at 0. Between samples the filtered value is held.
- R7: With code 7, after an accepted sample, strobes are ignored until 32 `tick_i` pulses (256 µs) have been consumed after the sampling edge. A strobe ignored this way does not restart the lockout.
- R8: When `pin_gate_en_i` = 1 and `param_pin_i` = 1, `data_o` equals the conditioned input on every channel.
- R9: When `pin_gate_en_i` = 0, `param_pin_i` has no effect and enabled channels report their filtered value. When `pin_gate_en_i` = 1 and `param_pin_i` = 0, enabled channels also report their filtered value.
- R10: The filters keep running while the output is bypassed, so filtered values reached during bypass appear as soon as the bypass ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_done_i | input | 1 | High once initialization is complete; low clears filter state |
| tick_i | input | 1 | One-cycle sub-tick pulse, 1/16 of the 128 µs base |
| dx_strobe_i | input | 1 | One-cycle data-exchange event strobe |
| raw_i | input | 4 | Raw input lines |
| inv_cfg_i | input | 4 | Per-channel inversion enables |
| flt_en_i | input | 4 | Per-channel filter enables |
| tconst_i | input | 3 | Time-constant code; 7 selects exchange-cycle mode |
| pin_gate_en_i | input | 1 | Lets the parameter pin bypass the filters |
| param_pin_i | input | 1 | Parameter pin; with gating enabled, 1 selects raw values |
| data_o | output | 4 | Conditioned value used for the slave response |

## Verification
The bench targets the exact tick on which each timed filter flips, at the shortest and the longest code. A counter that is off by one, or too narrow for 1024 sub-ticks, would flip early or never flip. It drops the input back for a single cycle mid-count; a design that paused instead of restarting would then flip early. In exchange-cycle mode it places a strobe one sub-tick before the lockout ends, then one just after. A design whose lockout is short, or that restarts on ignored strobes, would accept a sample at the wrong strobe. It also advances a filter during bypass and checks the value when the bypass is released. A design that froze its filters would still show the old level.

// File: rtl/flt_pkg.sv
package flt_pkg;
  typedef enum logic {
    FMODE_TIMED = 1'b0,
    FMODE_CYCLE = 1'b1
  } fmode_e;
endpackage

// File: rtl/flt_mode_dec.sv
module flt_mode_dec import flt_pkg::*; #(
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned SUB_PER_BASE = 16,
  parameter int unsigned CNT_W        = 11
) (
  input  logic [CODE_W-1:0] code_i,
  output fmode_e            mode_o,
  output logic [CNT_W-1:0]  limit_o
);
  localparam int unsigned CYCLE_CODE = (1 << CODE_W) - 1;

  always_comb begin
    if (code_i == CODE_W'(CYCLE_CODE)) begin
      mode_o  = FMODE_CYCLE;
      limit_o = '0;
    end else begin
      mode_o  = FMODE_TIMED;
      limit_o = CNT_W'(SUB_PER_BASE) << code_i;
    end
  end
endmodule

// File: rtl/flt_lockout.sv
module flt_lockout #(
  parameter int unsigned LOCK_TICKS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_done_i,
  input  logic enable_i,
  input  logic tick_i,
  input  logic strobe_i,
  output logic sample_o
);
  localparam int unsigned LOCK_W = $clog2(LOCK_TICKS + 1);

  logic [LOCK_W-1:0] lock_q;

  assign sample_o = init_done_i && enable_i && strobe_i && (lock_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
    end else if (!init_done_i) begin
      lock_q <= '0;
    end else if (sample_o) begin
      lock_q <= LOCK_W'(LOCK_TICKS);
    end else if (tick_i && lock_q != '0) begin
      lock_q <= lock_q - 1'b1;
    end
  end
endmodule

// File: rtl/flt_chan.sv
module flt_chan #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_done_i,
  input  logic             tick_i,
  input  logic             cycle_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             sample_i,
  input  logic             x_i,
  output logic             filt_o
);
  logic             filt_q;
  logic             samp_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign filt_o  = filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!init_done_i) begin
      filt_q <= 1'b0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cycle_i) begin
      cnt_q <= '0;
      if (sample_i) begin
        samp_q <= x_i;
        if (x_i == samp_q) filt_q <= x_i;
      end
    end else if (x_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_inc >= {1'b0, limit_i}) begin
        filt_q <= x_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_inc[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/flt_input_cond.sv
module flt_input_cond import flt_pkg::*; #(
  parameter int unsigned NUM_CH       = 4,
  parameter int unsigned CODE_W       = 3,
  parameter int unsigned SUB_PER_BASE = 16,
  parameter int unsigned LOCK_BASES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_done_i,
  input  logic              tick_i,
  input  logic              dx_strobe_i,
  input  logic [NUM_CH-1:0] raw_i,
  input  logic [NUM_CH-1:0] inv_cfg_i,
  input  logic [NUM_CH-1:0] flt_en_i,
  input  logic [CODE_W-1:0] tconst_i,
  input  logic              pin_gate_en_i,
  input  logic              param_pin_i,
  output logic [NUM_CH-1:0] data_o
);
  localparam int unsigned CYCLE_CODE = (1 << CODE_W) - 1;
  localparam int unsigned MAX_LIMIT  = SUB_PER_BASE << (CYCLE_CODE - 1);
  localparam int unsigned CNT_W      = $clog2(MAX_LIMIT + 1);
  localparam int unsigned LOCK_TICKS = SUB_PER_BASE * LOCK_BASES;

  fmode_e            mode;
  logic              cycle_mode;
  logic [CNT_W-1:0]  limit;
  logic              sample_ev;
  logic              bypass;
  logic [NUM_CH-1:0] cond;
  logic [NUM_CH-1:0] filt;

  flt_mode_dec #(
    .CODE_W      (CODE_W),
    .SUB_PER_BASE(SUB_PER_BASE),
    .CNT_W       (CNT_W)
  ) u_dec (
    .code_i (tconst_i),
    .mode_o (mode),
    .limit_o(limit)
  );

  assign cycle_mode = (mode == FMODE_CYCLE);
  assign cond       = raw_i ^ inv_cfg_i;  // invert ahead of filtering

  flt_lockout #(
    .LOCK_TICKS(LOCK_TICKS)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_done_i(init_done_i),
    .enable_i   (cycle_mode),
    .tick_i     (tick_i),
    .strobe_i   (dx_strobe_i),
    .sample_o   (sample_ev)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    flt_chan #(
      .CNT_W(CNT_W)
    ) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .init_done_i(init_done_i),
      .tick_i     (tick_i),
      .cycle_i    (cycle_mode),
      .limit_i    (limit),
      .sample_i   (sample_ev),
      .x_i        (cond[g]),
      .filt_o     (filt[g])
    );
  end

  // filters run regardless; only the selection changes
  assign bypass = pin_gate_en_i && param_pin_i;
  assign data_o = bypass ? cond : ((filt & flt_en_i) | (cond & ~flt_en_i));
endmodule

// File: rtl/flt_input_cond_chk.sv
module flt_input_cond_chk #(
  parameter int unsigned NUM_CH     = 4,
  parameter int unsigned LOCK_TICKS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_done_i,
  input logic              tick_i,
  input logic [NUM_CH-1:0] raw_i,
  input logic [NUM_CH-1:0] inv_cfg_i,
  input logic [NUM_CH-1:0] flt_en_i,
  input logic              pin_gate_en_i,
  input logic              param_pin_i,
  input logic [NUM_CH-1:0] data_o,
  input logic              cycle_mode,
  input logic              sample_ev,
  input logic [NUM_CH-1:0] filt
);
  localparam int unsigned SW = $clog2(LOCK_TICKS + 1);

  logic [SW-1:0] since_q;
  logic          seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (!init_done_i) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else if (sample_ev) begin
      since_q <= '0;
      seen_q  <= 1'b1;
    end else if (tick_i && since_q < SW'(LOCK_TICKS)) begin
      since_q <= since_q + 1'b1;
    end
  end

  assert_init_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |=> (filt == '0));

  assert_bypass_raw_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_gate_en_i && param_pin_i) |-> (data_o == (raw_i ^ inv_cfg_i)));

  assert_disabled_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((data_o & ~flt_en_i) == ((raw_i ^ inv_cfg_i) & ~flt_en_i)));

  assert_flag_low_filtered_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_gate_en_i |-> ((data_o & flt_en_i) == (filt & flt_en_i)));

  assert_timed_tick_only_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && !cycle_mode && !tick_i) |=> $stable(filt));

  assert_cycle_sample_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_done_i && cycle_mode && !sample_ev) |=> $stable(filt));

  assert_lockout_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_ev && seen_q) |-> (since_q >= SW'(LOCK_TICKS)));
endmodule

bind flt_input_cond flt_input_cond_chk #(
  .NUM_CH    (NUM_CH),
  .LOCK_TICKS(LOCK_TICKS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .init_done_i  (init_done_i),
  .tick_i       (tick_i),
  .raw_i        (raw_i),
  .inv_cfg_i    (inv_cfg_i),
  .flt_en_i     (flt_en_i),
  .pin_gate_en_i(pin_gate_en_i),
  .param_pin_i  (param_pin_i),
  .data_o       (data_o),
  .cycle_mode   (cycle_mode),
  .sample_ev    (sample_ev),
  .filt         (filt)
);

// File: tb/tb_flt_input_cond.sv
`timescale 1ns/1ps
module tb_flt_input_cond;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_done, tick, dx, gate, p1;
  logic [3:0] raw, inv, en;
  logic [2:0] code;
  logic [3:0] data;

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R5";
  int    tcnt = 0;
  int    ticks_seen = 0;

  // reference model state
  int m_cnt  [4];
  bit m_filt [4];
  bit m_samp [4];
  int m_lock;

  always #5 clk = ~clk;

  flt_input_cond dut (
    .clk_i(clk), .rst_ni(rst_n), .init_done_i(init_done), .tick_i(tick),
    .dx_strobe_i(dx), .raw_i(raw), .inv_cfg_i(inv), .flt_en_i(en),
    .tconst_i(code), .pin_gate_en_i(gate), .param_pin_i(p1), .data_o(data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_filt[i] = 0; m_samp[i] = 0; end
      m_lock = 0;
    end else begin
      bit smp;
      if (tick) ticks_seen++;
      if (!init_done) begin
        for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_filt[i] = 0; m_samp[i] = 0; end
        m_lock = 0;
      end else begin
        smp = dx && (code == 3'd7) && (m_lock == 0);
        for (int i = 0; i < 4; i++) begin
          bit x;
          x = raw[i] ^ inv[i];
          if (code == 3'd7) begin
            m_cnt[i] = 0;
            if (smp) begin
              if (x == m_samp[i]) m_filt[i] = x;
              m_samp[i] = x;
            end
          end else if (x == m_filt[i]) m_cnt[i] = 0;
          else if (tick) begin
            if (m_cnt[i] + 1 >= (16 << code)) begin m_filt[i] = x; m_cnt[i] = 0; end
            else m_cnt[i]++;
          end
        end
        if (smp) m_lock = 32;
        else if (tick && m_lock > 0) m_lock--;
      end
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] o;
    for (int i = 0; i < 4; i++) begin
      bit x;
      x = raw[i] ^ inv[i];
      o[i] = (en[i] && !(gate && p1)) ? m_filt[i] : x;
    end
    return o;
  endfunction

  task automatic check(string req, string what, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(cur_req, "model", data, model_out());
    tcnt = (tcnt + 1) % 3;
    tick = (tcnt == 0);
  endtask

  task automatic dchk(string req, logic [3:0] exp);
    #1;
    check(req, "directed", data, exp);
  endtask

  task automatic wait_ticks(int k);
    int s;
    s = ticks_seen;
    while (ticks_seen - s < k) cyc();
  endtask

  task automatic strobe();
    while (tick) cyc();
    dx = 1'b1;
    cyc();
    dx = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; init_done = 0; tick = 0; dx = 0; gate = 0; p1 = 0;
    raw = 4'hF; inv = 4'h0; en = 4'hF; code = 3'd0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    dchk("R5", 4'b0000);                // init low: enabled channels read 0
    init_done = 1; raw = 4'h0;
    cyc(); cyc();

    cur_req = "R1";                     // code 0: 16 ticks
    raw = 4'b0001;
    wait_ticks(15); dchk("R1", 4'b0000);
    wait_ticks(1);  dchk("R1", 4'b0001);
    code = 3'd6; raw = 4'b0011;         // code 6: 1024 ticks
    wait_ticks(1023); dchk("R1", 4'b0001);
    wait_ticks(1);    dchk("R1", 4'b0011);

    cur_req = "R2";                     // code 2: 64 ticks, glitch restarts
    code = 3'd2; raw = 4'b0111;
    wait_ticks(40);
    raw = 4'b0011; cyc();
    raw = 4'b0111;
    wait_ticks(63); dchk("R2", 4'b0011);
    wait_ticks(1);  dchk("R2", 4'b0111);

    cur_req = "R3";                     // inverted channel 3 filters to 1
    code = 3'd0; inv = 4'b1000;
    wait_ticks(15); dchk("R3", 4'b0111);
    wait_ticks(1);  dchk("R3", 4'b1111);

    cur_req = "R4";                     // ch1, ch3 unfiltered
    en = 4'b0101; raw = 4'b0000;
    dchk("R4", 4'b1101);
    cyc(); cyc();
    en = 4'hF; inv = 4'h0;
    cur_req = "R1";
    wait_ticks(16); dchk("R1", 4'b0000);

    cur_req = "R8";
    gate = 1; p1 = 1; raw = 4'b0110;
    dchk("R8", 4'b0110);
    inv = 4'b0011;
    dchk("R8", 4'b0101);
    inv = 4'b0000;

    cur_req = "R10";
    wait_ticks(16);
    p1 = 0;              dchk("R10", 4'b0110);
    raw = 4'b0000; p1 = 1; dchk("R10", 4'b0000);
    p1 = 0;              dchk("R10", 4'b0110);

    cur_req = "R9";
    gate = 0; p1 = 1;
    dchk("R9", 4'b0110);
    wait_ticks(16); dchk("R9", 4'b0000);

    cur_req = "R5";
    raw = 4'hF;
    wait_ticks(16); dchk("R5", 4'b1111);
    init_done = 0; cyc(); dchk("R5", 4'b0000);
    init_done = 1; cyc(); dchk("R5", 4'b0000);
    raw = 4'h0; cyc(); cyc();

    cur_req = "R6";                     // exchange-cycle mode
    code = 3'd7; raw = 4'b0001;
    strobe(); dchk("R6", 4'b0000);
    wait_ticks(32);
    strobe(); dchk("R6", 4'b0001);

    cur_req = "R7";
    raw = 4'b0011;
    wait_ticks(32);
    strobe();
    wait_ticks(31);
    strobe(); dchk("R7", 4'b0001);      // inside lockout: ignored
    wait_ticks(1);
    strobe(); dchk("R7", 4'b0011);      // second sample of ch1 accepted

    cur_req = "R6";
    raw = 4'b0001; wait_ticks(32); strobe(); dchk("R6", 4'b0011);
    raw = 4'b0011; wait_ticks(32); strobe(); dchk("R6", 4'b0011);
    raw = 4'b0001; wait_ticks(32); strobe(); dchk("R6", 4'b0011);
    wait_ticks(32); strobe(); dchk("R6", 4'b0001);
    cyc(); cyc();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule